// File: doc/BRIEF.md
# Two-Sample Frame Parallel FIR Filter

This block is a six-tap FIR filter that accepts two consecutive time samples on every clock cycle and delivers two filtered samples on every clock cycle. The earlier sample of a frame arrives on `in_x0` and the later one on `in_x1`. This doubles the throughput of a one-sample-per-clock filter at the same clock rate. The design is fully parallel. The even-time and odd-time sample streams each feed two polyphase subfilters. One subfilter holds the even-indexed coefficients and the other holds the odd-indexed coefficients. Four subfilters run at once.

Each subfilter multiplies its taps by constant coefficients and reduces the products in a binary adder tree. A final tree level combines two subfilter results into each output. Parameters set the optional register stages before and after every multiplier and the register stages after every tree level. This lets the designer trade latency for clock speed. All arithmetic is signed two's complement at full precision, so the result never wraps. A valid flag travels alongside the data through the same total delay.

Top module: `fir2_frame_top`

## Requirements
- R1: For every accepted frame n, `out_y0` equals the sum over k=0..5 of h[k]*x[2n-k], and `out_y1` equals the sum over k=0..5 of h[k]*x[2n+1-k]. Here x[2n] is `in_x0` and x[2n+1] is `in_x1` of frame n, and samples older than the current frame come from earlier accepted frames.
- R2: `out_valid` is `in_valid` delayed by exactly LAT = MUL_IN_PIPE + MUL_OUT_PIPE + (clog2(NTAPS/2)+1)*TREE_PIPE + 1 cycles, which is 9 for the defaults (1, 1, 2). The output data on a cycle with `out_valid` high belongs to the frame accepted LAT cycles earlier. `out_valid` is low on every other cycle.
- R3: Outputs are DW+CW+clog2(NTAPS) bits wide (35 by default). Products and sums never wrap, even when every sample is at full scale with the sign that maximises the magnitude of the result.
- R4: The sample history advances only on cycles where `in_valid` is high. Idle cycles between frames leave the results of later frames unchanged.
- R5: A synchronous active-high `rst` clears the sample history and every pipeline register. The outputs then read zero with `out_valid` low, frames still in flight are dropped, and later frames are computed as if all earlier samples were zero.
- R6: Samples and coefficients are signed two's complement. The coefficients are h = {-20000, 28000, 32767, 30000, 25000, -18000} by default, for k = 0..5. An impulse on `in_x0` yields (h0,h1), (h2,h3) and (h4,h5) on (`out_y0`,`out_y1`) over three frames. An impulse on `in_x1` yields (0,h0), (h1,h2), (h3,h4) and (h5,0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Frame on `in_x0`/`in_x1` is valid this cycle |
| in_x0 | input | DW | Earlier sample of the frame, x[2n], signed |
| in_x1 | input | DW | Later sample of the frame, x[2n+1], signed |
| out_valid | output | 1 | Output frame valid |
| out_y0 | output | DW+CW+clog2(NTAPS) | Filtered sample y[2n], signed |
| out_y1 | output | DW+CW+clog2(NTAPS) | Filtered sample y[2n+1], signed |

## Verification
The assertions assume that `in_valid` is a clean 0/1 level, that both samples are within the signed DW-bit range, and that the run begins with `rst` held for at least one clock edge. The magnitude bound on the outputs relies on the data inputs never being unknown when a frame is accepted. The bench asserts reset at time zero and drives every input on the falling edge. It holds the samples at zero whenever `in_valid` is low, and its pseudo-random frames are masked to the DW-bit signed range.

// File: rtl/fir2_pkg.sv
package fir2_pkg;

  // Number of binary adder levels needed to reduce n terms.
  function automatic int tree_levels(input int n);
    return (n <= 1) ? 0 : $clog2(n);
  endfunction

  // Total cycles from an accepted frame to its outputs.
  function automatic int frame_latency(input int taps, input int mul_in,
                                       input int mul_out, input int tree_pipe);
    return mul_in + mul_out + (tree_levels(taps / 2) + 1) * tree_pipe + 1;
  endfunction

endpackage

// File: rtl/fir2_pipe.sv
module fir2_pipe #(
  parameter int W = 8,
  parameter int D = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  generate
    if (D == 0) begin : g_wire
      assign q = d;
    end else begin : g_reg
      logic [W-1:0] st [D];
      always_ff @(posedge clk) begin
        if (rst) begin
          for (int i = 0; i < D; i++) st[i] <= '0;
        end else begin
          st[0] <= d;
          for (int i = 1; i < D; i++) st[i] <= st[i-1];
        end
      end
      assign q = st[D-1];
    end
  endgenerate

endmodule

// File: rtl/fir2_hist.sv
module fir2_hist #(
  parameter int DW    = 16,
  parameter int DEPTH = 2
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      en,
  input  logic [DW-1:0]             d,
  output logic [DEPTH:0][DW-1:0]    taps_o
);

  generate
    if (DEPTH == 0) begin : g_none
      assign taps_o = d;
    end else begin : g_reg
      logic [DEPTH-1:0][DW-1:0] r;
      always_ff @(posedge clk) begin
        if (rst) begin
          r <= '0;
        end else if (en) begin
          r[0] <= d;
          for (int i = 1; i < DEPTH; i++) r[i] <= r[i-1];
        end
      end
      // taps_o[0] is the live sample, taps_o[i] is i frames old
      assign taps_o = {r, d};

      AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
        !en |=> $stable(r)); // R4
      AST_SHIFT_IN: assert property (@(posedge clk) disable iff (rst)
        en |=> (r[0] == $past(d))); // R4
    end
  endgenerate

endmodule

// File: rtl/fir2_subfilter.sv
module fir2_subfilter #(
  parameter int DW       = 16,
  parameter int CW       = 16,
  parameter int SW       = 35,
  parameter int NTAPS    = 6,
  parameter int L        = 3,
  parameter int PHASE    = 0,
  parameter int MUL_IN   = 1,
  parameter int MUL_OUT  = 1,
  parameter int TREE     = 2,
  parameter logic signed [CW-1:0] COEFS [NTAPS] = '{default: '0}
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [L-1:0][DW-1:0]   taps_i,
  output logic signed [SW-1:0]   sum_o
);

  localparam int PW   = DW + CW;
  localparam int LV   = fir2_pkg::tree_levels(L);
  localparam int NPAD = 1 << LV;

  // heap-ordered tree: node[1] is the root, leaves start at NPAD
  logic [SW-1:0] node [1:2*NPAD-1];

  for (genvar j = 0; j < NPAD; j++) begin : g_leaf
    if (j < L) begin : g_tap
      logic [DW-1:0]        xs;
      logic signed [PW-1:0] pr;
      logic [PW-1:0]        pq;

      fir2_pipe #(.W(DW), .D(MUL_IN)) u_min (
        .clk(clk), .rst(rst), .d(taps_i[j]), .q(xs));

      assign pr = PW'($signed(xs)) * PW'(COEFS[2*j+PHASE]);

      fir2_pipe #(.W(PW), .D(MUL_OUT)) u_mout (
        .clk(clk), .rst(rst), .d(pr), .q(pq));

      assign node[NPAD+j] = SW'($signed(pq));
    end else begin : g_pad
      assign node[NPAD+j] = '0;
    end
  end

  for (genvar k = 1; k < NPAD; k++) begin : g_add
    logic [SW-1:0] nsum;
    assign nsum = $signed(node[2*k]) + $signed(node[2*k+1]);
    fir2_pipe #(.W(SW), .D(TREE)) u_tp (
      .clk(clk), .rst(rst), .d(nsum), .q(node[k]));
  end

  assign sum_o = $signed(node[1]);

endmodule

// File: rtl/fir2_frame_top.sv
module fir2_frame_top
  import fir2_pkg::*;
#(
  parameter int DW          = 16,
  parameter int CW          = 16,
  parameter int NTAPS       = 6,
  parameter int MUL_IN_PIPE  = 1,
  parameter int MUL_OUT_PIPE = 1,
  parameter int TREE_PIPE    = 2,
  parameter logic signed [CW-1:0] COEFS [NTAPS] =
    '{-16'sd20000, 16'sd28000, 16'sd32767, 16'sd30000, 16'sd25000, -16'sd18000}
) (
  input  logic                                     clk,
  input  logic                                     rst,
  input  logic                                     in_valid,
  input  logic signed [DW-1:0]                     in_x0,
  input  logic signed [DW-1:0]                     in_x1,
  output logic                                     out_valid,
  output logic signed [DW+CW+$clog2(NTAPS)-1:0]    out_y0,
  output logic signed [DW+CW+$clog2(NTAPS)-1:0]    out_y1
);

  localparam int L    = NTAPS / 2;
  localparam int SW   = DW + CW + $clog2(NTAPS);
  localparam int LAT  = frame_latency(NTAPS, MUL_IN_PIPE, MUL_OUT_PIPE, TREE_PIPE);
  localparam int CNTW = $clog2(LAT + 2) + 1;

  // even stream needs delays 0..L-1, odd stream needs 0..L
  logic [L-1:0][DW-1:0] ev;
  logic [L:0][DW-1:0]   od;

  fir2_hist #(.DW(DW), .DEPTH(L-1)) u_hist_ev (
    .clk(clk), .rst(rst), .en(in_valid), .d(in_x0), .taps_o(ev));
  fir2_hist #(.DW(DW), .DEPTH(L)) u_hist_od (
    .clk(clk), .rst(rst), .en(in_valid), .d(in_x1), .taps_o(od));

  logic signed [SW-1:0] a0, b0, a1, b1;

  // y[2n]: even coefs on even stream, odd coefs on odd stream one frame back
  fir2_subfilter #(.DW(DW), .CW(CW), .SW(SW), .NTAPS(NTAPS), .L(L), .PHASE(0),
    .MUL_IN(MUL_IN_PIPE), .MUL_OUT(MUL_OUT_PIPE), .TREE(TREE_PIPE), .COEFS(COEFS))
    u_sf_ee (.clk(clk), .rst(rst), .taps_i(ev), .sum_o(a0));
  fir2_subfilter #(.DW(DW), .CW(CW), .SW(SW), .NTAPS(NTAPS), .L(L), .PHASE(1),
    .MUL_IN(MUL_IN_PIPE), .MUL_OUT(MUL_OUT_PIPE), .TREE(TREE_PIPE), .COEFS(COEFS))
    u_sf_oo (.clk(clk), .rst(rst), .taps_i(od[L:1]), .sum_o(b0));

  // y[2n+1]: even coefs on odd stream, odd coefs on even stream
  fir2_subfilter #(.DW(DW), .CW(CW), .SW(SW), .NTAPS(NTAPS), .L(L), .PHASE(0),
    .MUL_IN(MUL_IN_PIPE), .MUL_OUT(MUL_OUT_PIPE), .TREE(TREE_PIPE), .COEFS(COEFS))
    u_sf_oe (.clk(clk), .rst(rst), .taps_i(od[L-1:0]), .sum_o(a1));
  fir2_subfilter #(.DW(DW), .CW(CW), .SW(SW), .NTAPS(NTAPS), .L(L), .PHASE(1),
    .MUL_IN(MUL_IN_PIPE), .MUL_OUT(MUL_OUT_PIPE), .TREE(TREE_PIPE), .COEFS(COEFS))
    u_sf_eo (.clk(clk), .rst(rst), .taps_i(ev), .sum_o(b1));

  logic [SW-1:0] s0, s1;
  assign s0 = a0 + b0;
  assign s1 = a1 + b1;

  // last tree level plus the output register
  fir2_pipe #(.W(SW), .D(TREE_PIPE + 1)) u_out0 (
    .clk(clk), .rst(rst), .d(s0), .q(out_y0));
  fir2_pipe #(.W(SW), .D(TREE_PIPE + 1)) u_out1 (
    .clk(clk), .rst(rst), .d(s1), .q(out_y1));
  fir2_pipe #(.W(1), .D(LAT)) u_vld (
    .clk(clk), .rst(rst), .d(in_valid), .q(out_valid));

  // ---------------- checks ----------------
  function automatic longint abs_coef_sum();
    longint s = 0;
    for (int i = 0; i < NTAPS; i++)
      s += (COEFS[i] < 0) ? -longint'(COEFS[i]) : longint'(COEFS[i]);
    return s;
  endfunction

  localparam longint BOUND = abs_coef_sum() * (longint'(1) << (DW - 1));

  logic [CNTW-1:0] inflight;
  always_ff @(posedge clk) begin
    if (rst) inflight <= '0;
    else     inflight <= inflight + CNTW'(in_valid) - CNTW'(out_valid);
  end

  AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!out_valid && out_y0 == '0 && out_y1 == '0)); // R5
  AST_VALID_CAUSAL: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (inflight != '0)); // R2
  AST_INFLIGHT_BOUND: assert property (@(posedge clk) disable iff (rst)
    inflight <= CNTW'(LAT)); // R2
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (longint'(out_y0) <= BOUND && longint'(out_y0) >= -BOUND &&
                   longint'(out_y1) <= BOUND && longint'(out_y1) >= -BOUND)); // R3

endmodule

// File: tb/fir2_frame_top_bench.sv
module fir2_frame_top_bench;

  localparam int CLK_PERIOD = 10;
  localparam int DW  = 16;
  localparam int SW  = 35;
  localparam int LAT = 1 + 1 + ($clog2(3) + 1) * 2 + 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic signed [DW-1:0] in_x0 = '0;
  logic signed [DW-1:0] in_x1 = '0;
  logic out_valid;
  logic signed [SW-1:0] out_y0, out_y1;

  fir2_frame_top u_fir2_frame_top (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_x0(in_x0), .in_x1(in_x1),
    .out_valid(out_valid), .out_y0(out_y0), .out_y1(out_y1));

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  longint H [6] = '{-20000, 28000, 32767, 30000, 25000, -18000};
  longint mh [6];
  longint q0 [$];
  longint q1 [$];
  string  qtag [$];

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic model_clear();
    for (int i = 0; i < 6; i++) mh[i] = 0;
    q0.delete(); q1.delete(); qtag.delete();
  endtask

  function automatic longint model_push(input longint s);
    longint acc = 0;
    for (int i = 5; i > 0; i--) mh[i] = mh[i-1];
    mh[0] = s;
    for (int k = 0; k < 6; k++) acc += H[k] * mh[k];
    return acc;
  endfunction

  // drive one frame on the current falling edge and wait one cycle
  task automatic send(input longint a, input longint b, input string tag);
    longint e0, e1;
    in_valid = 1'b1;
    in_x0 = DW'(a);
    in_x1 = DW'(b);
    e0 = model_push(a);
    e1 = model_push(b);
    q0.push_back(e0); q1.push_back(e1); qtag.push_back(tag);
    @(negedge clk);
    in_valid = 1'b0;
    in_x0 = '0;
    in_x1 = '0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic drain(input string tag);
    idle(LAT + 2);
    check(q0.size() == 0, tag, "frames without output", q0.size(), 0);
  endtask

  // output monitor, sampled on falling edges
  always @(negedge clk) begin
    if (!rst && out_valid) begin
      if (q0.size() == 0) begin
        check(1'b0, "R2", "out_valid with no frame pending", 1, 0);
      end else begin
        longint e0, e1;
        string t;
        e0 = q0.pop_front(); e1 = q1.pop_front(); t = qtag.pop_front();
        check(longint'(out_y0) == e0, t, "out_y0", longint'(out_y0), e0);
        check(longint'(out_y1) == e1, t, "out_y1", longint'(out_y1), e1);
      end
    end
  end

  task automatic t_reset_state();
    check(out_valid == 1'b0, "R5", "out_valid after reset", out_valid, 0);
    check(out_y0 == '0, "R5", "out_y0 after reset", longint'(out_y0), 0);
    check(out_y1 == '0, "R5", "out_y1 after reset", longint'(out_y1), 0);
  endtask

  task automatic t_latency();
    in_valid = 1'b1; in_x0 = DW'(100); in_x1 = DW'(-7);
    q0.push_back(model_push(100)); q1.push_back(model_push(-7)); qtag.push_back("R2");
    for (int n = 1; n <= LAT; n++) begin
      @(negedge clk);
      in_valid = 1'b0; in_x0 = '0; in_x1 = '0;
      if (n < LAT) check(out_valid == 1'b0, "R2", "early out_valid", out_valid, 0);
      else         check(out_valid == 1'b1, "R2", "out_valid at LAT", out_valid, 1);
    end
    drain("R2");
  endtask

  task automatic t_impulse_even();
    send(1, 0, "R6"); send(0, 0, "R6"); send(0, 0, "R6"); send(0, 0, "R6");
    drain("R6");
  endtask

  task automatic t_impulse_odd();
    send(0, 1, "R6"); send(0, 0, "R6"); send(0, 0, "R6"); send(0, 0, "R6");
    drain("R6");
  endtask

  task automatic t_extremes();
    // sign-matched full-scale pattern drives y0 beyond 32 bits
    send(0, -32768, "R3"); send(32767, 32767, "R3"); send(32767, 32767, "R3");
    send(-32768, 0, "R3");
    // opposite signs for the most negative result
    send(0, 32767, "R3"); send(-32768, -32768, "R3"); send(-32768, -32768, "R3");
    send(32767, -32768, "R3"); send(-32768, 32767, "R3");
    send(0, 0, "R3"); send(0, 0, "R3"); send(0, 0, "R3");
    drain("R3");
  endtask

  task automatic t_gaps();
    send(1234, -4321, "R4"); idle(3);
    send(-5000, 7000, "R4"); idle(1);
    send(300, 0, "R4"); idle(5);
    send(0, -1, "R4"); send(9, 9, "R4"); idle(2);
    send(0, 0, "R4");
    drain("R4");
  endtask

  task automatic t_random();
    logic [15:0] s = 16'hACE1;
    for (int i = 0; i < 40; i++) begin
      longint a, b;
      s = s ^ (s << 7); s = s ^ (s >> 9); s = s ^ (s << 8);
      a = longint'($signed(s));
      s = s ^ (s << 7); s = s ^ (s >> 9); s = s ^ (s << 8);
      b = longint'($signed(s));
      send(a, b, "R1");
    end
    drain("R1");
  endtask

  task automatic t_reset_mid();
    send(11111, -22222, "R5"); send(3333, 4444, "R5"); send(-5555, 6666, "R5");
    idle(2);
    rst = 1'b1;
    model_clear();
    idle(2);
    rst = 1'b0;
    check(out_valid == 1'b0, "R5", "out_valid after mid reset", out_valid, 0);
    check(out_y0 == '0, "R5", "out_y0 after mid reset", longint'(out_y0), 0);
    send(0, 1, "R5"); send(1, 0, "R5"); send(0, 0, "R5");
    drain("R5");
  endtask

  initial begin
    model_clear();
    idle(3);
    rst = 1'b0;
    t_reset_state();
    t_latency();
    t_impulse_even();
    t_impulse_odd();
    t_extremes();
    t_gaps();
    t_random();
    t_reset_mid();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule